// File: doc/BRIEF.md
# Software Write-Protect Sequence Detector

This block sits in front of a byte-write engine and watches every write that arrives at it, each one an address and a data byte presented with a single-cycle valid pulse. For every write it decides in the same cycle whether that byte may be committed to the memory array, and it keeps a protection-mode flag that the system can observe.

Two fixed command codes, each a chain of special address/data writes, control the mode. A three-write arming code turns protection on and grants exactly one following write, whatever its address. A six-write clearing code turns protection off. No byte that is consumed as part of either code is ever committed. While protection is on, only a write that directly follows a completed arming code is allowed. A write that does not continue a partial code returns the matcher to its start, and that write is judged by the current mode. A partial code, or an unused grant, is also abandoned after a parameterised number of idle cycles.

Top module: `wp_seq_guard`

## Requirements
- R1: After reset `protectOn` is 0, and a plain write is committed.
- R2: With protection off, a write that is not consumed by a code sees `commitEn` high during its valid cycle.
- R3: The arming code is three writes: 0x1555/0xAA, then 0x0AAA/0x55, then 0x1555/0xA0. `protectOn` reads 1 from the cycle after its third write, and none of the three is committed.
- R4: The first write after a completed arming code is committed, at any address and in either mode. Only that one write is granted.
- R5: With protection on, any write that is neither part of a code nor the granted write is not committed.
- R6: The clearing code is six writes: 0x1555/0xAA, 0x0AAA/0x55, 0x1555/0x80, 0x1555/0xAA, 0x0AAA/0x55, 0x1555/0x20. `protectOn` reads 0 from the cycle after the sixth write. None of the six is committed, whichever mode was in force.
- R7: A write that does not match the next expected step of a partial code returns the matcher to its start. That write does not count as a first step, and it is committed only if protection is off.
- R8: If TIMEOUT_CYCLES clock edges pass with no write while a code is partial or a grant is pending, the matcher returns to its start and the grant is discarded. A gap shorter than that keeps the progress.
- R9: Each write that advances a code is withheld when it occurs, even if the code is broken afterwards.
- R10: `commitEn` is never high without `wrValid`, and `protectOn` changes only on the edge that ends a write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrValid | input | 1 | One-cycle pulse marking a byte write |
| wrAddr | input | ADDR_W (13) | Write address |
| wrData | input | DATA_W (8) | Write data byte |
| commitEn | output | 1 | Combinational permit for the present write |
| protectOn | output | 1 | Current protection mode |

## Verification
The bench arms the block from both modes and checks that the granted write is consumed exactly once. A design that kept the grant would let a second protected write through. It breaks codes partway in both modes, including a clearing code cut at its fifth step. A design that judged the breaking write by the code instead of the mode, or that committed the earlier prefix bytes, would show the wrong `commitEn`. It also places idle gaps just under and just over the timeout, both mid-code and with a grant pending. An off-by-a-lot timer, or a timer that ignores the pending grant, would then let through or block the following write wrongly.

// File: rtl/wp_seq_pkg.sv
package wp_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_GOT1, ST_GOT2, ST_GOT3, ST_GOT4, ST_GOT5
  } seqStep_e;

  // Which fixed code word the present write carries.
  typedef struct packed {
    logic finalCode;  // 1555/20
    logic clearCode;  // 1555/80
    logic armCode;    // 1555/A0
    logic echo;       // 0AAA/55
    logic kick;       // 1555/AA
  } codeHit_t;

  // Strobes from control to datapath.
  typedef struct packed {
    logic withhold;
    logic armDone;
    logic disarmDone;
    logic passUsed;
    logic passDrop;
  } seqStrobe_t;

endpackage

// File: rtl/wp_mode_path.sv
module wp_mode_path
  import wp_seq_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrValid,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  seqStrobe_t        strb,
  output codeHit_t          hit,
  output logic              passLive,
  output logic              commitEn,
  output logic              protectOn
);
  localparam int NUM_CODES = 5;
  localparam logic [ADDR_W-1:0] ADR_HI = ADDR_W'(13'h1555);
  localparam logic [ADDR_W-1:0] ADR_LO = ADDR_W'(13'h0AAA);
  // Entry i sits at slice i: kick, echo, armCode, clearCode, finalCode.
  localparam logic [NUM_CODES*ADDR_W-1:0] CODE_ADDR =
    {ADR_HI, ADR_HI, ADR_HI, ADR_LO, ADR_HI};
  localparam logic [NUM_CODES*DATA_W-1:0] CODE_DATA =
    {DATA_W'(8'h20), DATA_W'(8'h80), DATA_W'(8'hA0), DATA_W'(8'h55), DATA_W'(8'hAA)};

  logic [NUM_CODES-1:0] hitVec;

  for (genvar i = 0; i < NUM_CODES; i++) begin : g_cmp
    assign hitVec[i] = wrValid
                    && (wrAddr == CODE_ADDR[i*ADDR_W +: ADDR_W])
                    && (wrData == CODE_DATA[i*DATA_W +: DATA_W]);
  end

  assign hit = codeHit_t'(hitVec);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      protectOn <= 1'b0;
      passLive  <= 1'b0;
    end else begin
      if (strb.armDone)         protectOn <= 1'b1;
      else if (strb.disarmDone) protectOn <= 1'b0;
      if (strb.armDone)                      passLive <= 1'b1;
      else if (strb.passUsed || strb.passDrop) passLive <= 1'b0;
    end
  end

  assign commitEn = wrValid && !strb.withhold && (!protectOn || passLive);

  // R3: a finished arming code leaves the mode on with one grant pending
  a_r3_arm_sets_mode: assert property (@(posedge clk) disable iff (!rstN)
    strb.armDone |=> (protectOn && passLive));

  // R6: a finished clearing code leaves the mode off
  a_r6_disarm_clears: assert property (@(posedge clk) disable iff (!rstN)
    strb.disarmDone |=> !protectOn);

  // R4: a grant is spent by the write that uses it
  a_r4_grant_single_use: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && passLive) |=> !passLive);

  // R10: mode holds across cycles without a write
  a_r10_mode_stable: assert property (@(posedge clk) disable iff (!rstN)
    !wrValid |=> $stable(protectOn));

endmodule

// File: rtl/wp_seq_ctrl.sv
module wp_seq_ctrl
  import wp_seq_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 3000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrValid,
  input  codeHit_t   hit,
  input  logic       passLive,
  output seqStrobe_t strb
);
  localparam int CNT_W = $clog2(TIMEOUT_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT_CYCLES - 1);

  seqStep_e         step, stepNext;
  logic [CNT_W-1:0] idleCnt, idleNext;
  logic             waiting;

  assign waiting = (step != ST_IDLE) || passLive;

  always_comb begin
    strb     = '0;
    stepNext = step;
    idleNext = idleCnt;
    if (wrValid) begin
      idleNext = '0;
      stepNext = ST_IDLE;
      if (passLive) begin
        strb.passUsed = 1'b1;
      end else begin
        case (step)
          ST_IDLE: if (hit.kick) begin strb.withhold = 1'b1; stepNext = ST_GOT1; end
          ST_GOT1: if (hit.echo) begin strb.withhold = 1'b1; stepNext = ST_GOT2; end
          ST_GOT2: begin
            if (hit.armCode) begin
              strb.withhold = 1'b1;
              strb.armDone  = 1'b1;
            end else if (hit.clearCode) begin
              strb.withhold = 1'b1;
              stepNext      = ST_GOT3;
            end
          end
          ST_GOT3: if (hit.kick) begin strb.withhold = 1'b1; stepNext = ST_GOT4; end
          ST_GOT4: if (hit.echo) begin strb.withhold = 1'b1; stepNext = ST_GOT5; end
          ST_GOT5: begin
            if (hit.finalCode) begin
              strb.withhold   = 1'b1;
              strb.disarmDone = 1'b1;
            end
          end
          default: stepNext = ST_IDLE;
        endcase
      end
    end else if (!waiting) begin
      idleNext = '0;
    end else if (idleCnt == CNT_LAST) begin
      idleNext      = '0;
      stepNext      = ST_IDLE;
      strb.passDrop = passLive;
    end else begin
      idleNext = idleCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      step    <= ST_IDLE;
      idleCnt <= '0;
    end else begin
      step    <= stepNext;
      idleCnt <= idleNext;
    end
  end

  // R9: bytes are only withheld on a real write
  a_r9_withhold_on_write: assert property (@(posedge clk) disable iff (!rstN)
    strb.withhold |-> wrValid);

  // R7: a write that is not consumed leaves the matcher at its start
  a_r7_break_restarts: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && !strb.withhold) |=> (step == ST_IDLE));

  // R8: an expired gap returns the matcher to its start
  a_r8_timeout_restarts: assert property (@(posedge clk) disable iff (!rstN)
    (!wrValid && waiting && idleCnt == CNT_LAST) |=> (step == ST_IDLE));

  // R10: at most one mode event per write
  a_r10_one_event: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.armDone, strb.disarmDone, strb.passUsed, strb.passDrop}));

endmodule

// File: rtl/wp_seq_guard.sv
module wp_seq_guard
  import wp_seq_pkg::*;
#(
  parameter int ADDR_W         = 13,
  parameter int DATA_W         = 8,
  parameter int TIMEOUT_CYCLES = 3000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrValid,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic              commitEn,
  output logic              protectOn
);
  seqStrobe_t strb;
  codeHit_t   hit;
  logic       passLive;

  wp_seq_ctrl #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) i_ctrl (
    .clk(clk), .rstN(rstN), .wrValid(wrValid),
    .hit(hit), .passLive(passLive), .strb(strb)
  );

  wp_mode_path #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_path (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrAddr(wrAddr), .wrData(wrData),
    .strb(strb), .hit(hit), .passLive(passLive),
    .commitEn(commitEn), .protectOn(protectOn)
  );

  // R10: no permit without a write
  a_r10_commit_needs_write: assert property (@(posedge clk) disable iff (!rstN)
    commitEn |-> wrValid);

endmodule

// File: tb/test_wp_seq_guard.sv
module test_wp_seq_guard;
  localparam int CLK_PERIOD = 10;
  localparam int TO = 20;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrValid = 1'b0;
  logic [12:0] wrAddr = '0;
  logic [7:0]  wrData = '0;
  logic        commitEn, protectOn;

  int errors = 0;
  int checks = 0;
  bit    expQ[$];
  string tagQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  wp_seq_guard #(.TIMEOUT_CYCLES(TO)) i_wp_seq_guard (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrAddr(wrAddr), .wrData(wrData),
    .commitEn(commitEn), .protectOn(protectOn)
  );

  // Driver: called at posedge+1, presents one write for one cycle.
  task automatic doWrite(input logic [12:0] a, input logic [7:0] d, input bit exp, input string tag);
    expQ.push_back(exp);
    tagQ.push_back(tag);
    wrAddr = a; wrData = d; wrValid = 1'b1;
    @(posedge clk); #1;
    wrValid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic checkMode(input bit exp, input string tag);
    @(negedge clk);
    checks++;
    if (protectOn !== exp) begin
      errors++;
      $display("FAIL %s protectOn actual=%b expected=%b", tag, protectOn, exp);
    end
    @(posedge clk); #1;
  endtask

  task automatic arm(input string tag);
    doWrite(13'h1555, 8'hAA, 1'b0, tag);
    doWrite(13'h0AAA, 8'h55, 1'b0, tag);
    doWrite(13'h1555, 8'hA0, 1'b0, tag);
  endtask

  task automatic disarm(input string tag);
    doWrite(13'h1555, 8'hAA, 1'b0, tag);
    doWrite(13'h0AAA, 8'h55, 1'b0, tag);
    doWrite(13'h1555, 8'h80, 1'b0, tag);
    doWrite(13'h1555, 8'hAA, 1'b0, tag);
    doWrite(13'h0AAA, 8'h55, 1'b0, tag);
    doWrite(13'h1555, 8'h20, 1'b0, tag);
  endtask

  // Monitor: pops the expected permit for each write seen.
  always @(negedge clk) begin
    if (rstN && wrValid) begin
      checks++;
      if (expQ.size() == 0) begin
        errors++;
        $display("FAIL scoreboard: write seen with nothing expected");
      end else begin
        automatic bit    e = expQ.pop_front();
        automatic string t = tagQ.pop_front();
        if (commitEn !== e) begin
          errors++;
          $display("FAIL %s commitEn actual=%b expected=%b addr=%h data=%h",
                   t, commitEn, e, wrAddr, wrData);
        end
      end
    end
  end

  initial begin
    repeat (CLK_PERIOD * 0 + 20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    idle(3);
    rstN = 1'b1;
    idle(1);
    checkMode(1'b0, "R1 reset mode");
    doWrite(13'h0100, 8'h11, 1'b1, "R1 plain write after reset");

    doWrite(13'h1FFF, 8'h00, 1'b1, "R2 plain write");
    doWrite(13'h0AAA, 8'hAA, 1'b1, "R2 near-code write");
    doWrite(13'h1555, 8'hA0, 1'b1, "R2 lone third step");

    @(negedge clk);
    checks++;
    if (commitEn !== 1'b0) begin
      errors++;
      $display("FAIL R10 commitEn idle actual=%b expected=0", commitEn);
    end
    @(posedge clk); #1;

    arm("R3 arm from off");
    checkMode(1'b1, "R3 mode after arm");
    doWrite(13'h0200, 8'h33, 1'b1, "R4 granted write");
    doWrite(13'h0201, 8'h34, 1'b0, "R5 second write blocked");
    doWrite(13'h1000, 8'hFF, 1'b0, "R5 protected write");
    checkMode(1'b1, "R5 mode held");

    arm("R3 arm while on");
    doWrite(13'h1555, 8'hAA, 1'b1, "R4 grant at code address");
    doWrite(13'h0300, 8'h01, 1'b0, "R5 after grant");

    doWrite(13'h1555, 8'hAA, 1'b0, "R9 prefix");
    doWrite(13'h0AAA, 8'h55, 1'b0, "R9 prefix");
    doWrite(13'h0123, 8'h77, 1'b0, "R7 break while on");
    doWrite(13'h1555, 8'hA0, 1'b0, "R7 orphan step");
    checkMode(1'b1, "R7 mode after break");

    arm("R8 arm for drop");
    idle(TO + 3);
    doWrite(13'h0400, 8'h42, 1'b0, "R8 grant dropped");
    arm("R8 arm keep");
    idle(TO - 3);
    doWrite(13'h0401, 8'h43, 1'b1, "R8 grant kept");

    disarm("R6 clear from on");
    checkMode(1'b0, "R6 mode after clear");
    doWrite(13'h0500, 8'h55, 1'b1, "R6 write after clear");

    doWrite(13'h1555, 8'hAA, 1'b0, "R9 prefix off");
    doWrite(13'h0050, 8'h12, 1'b1, "R7 break while off");
    doWrite(13'h0AAA, 8'h55, 1'b1, "R7 not a restart");

    doWrite(13'h1555, 8'hAA, 1'b0, "R8 partial");
    doWrite(13'h0AAA, 8'h55, 1'b0, "R8 partial");
    idle(TO + 3);
    doWrite(13'h1555, 8'hA0, 1'b1, "R8 stale third step");
    checkMode(1'b0, "R8 mode unchanged");

    doWrite(13'h1555, 8'hAA, 1'b0, "R8 short gap");
    idle(TO - 3);
    doWrite(13'h0AAA, 8'h55, 1'b0, "R8 short gap");
    doWrite(13'h1555, 8'hA0, 1'b0, "R8 short gap");
    checkMode(1'b1, "R8 armed across gap");
    doWrite(13'h0600, 8'h66, 1'b1, "R4 grant");

    doWrite(13'h1555, 8'hAA, 1'b0, "R6 partial clear");
    doWrite(13'h0AAA, 8'h55, 1'b0, "R6 partial clear");
    doWrite(13'h1555, 8'h80, 1'b0, "R6 partial clear");
    doWrite(13'h1555, 8'hAA, 1'b0, "R6 partial clear");
    doWrite(13'h1555, 8'h20, 1'b0, "R7 clear cut at step five");
    checkMode(1'b1, "R7 still on");

    disarm("R6 clear");
    checkMode(1'b0, "R6 off");
    disarm("R6 clear while off");
    checkMode(1'b0, "R6 off after clear while off");
    doWrite(13'h0700, 8'h77, 1'b1, "R2 write after clear");

    idle(2);
    checks++;
    if (expQ.size() != 0) begin
      errors++;
      $display("FAIL scoreboard: %0d writes not observed, expected 0", expQ.size());
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule